// File: doc/BRIEF.md
# User Interrupt Posting Engine

This block carries out a single "post a user interrupt to another thread" command. It is given an index into a target table held in memory. It reads the 16-byte table entry at that index and checks it. It then takes a lock and reads the 16-byte posting descriptor that the entry points to, and checks that descriptor's reserved bits. It marks the requested vector as pending, writes the descriptor back and releases the lock. When the descriptor shows that no notification is outstanding and none is suppressed, the block also raises a notification request toward the interrupt fabric. That request carries a vector number and a destination ID.

The table base, the table size, the destination-width mode and a feature-enable bit are static configuration inputs. The memory port is one 128-bit line per request, with a valid/ready request channel, a one-beat read response and a lock output. The command completes with a single-cycle `done` pulse, or with a single-cycle `fault` pulse and a fault code. Only one command is in flight at a time.

Top module: `uipi_post_engine`

## Requirements
- R1: When `cfg_enable` is low, an accepted command ends in the next cycle with `fault` high and `fault_code` = 2 (invalid operation), and no memory request is issued.
- R2: When `cmd_index` is greater than `cfg_tbl_size`, the command ends in the next cycle with `fault` and `fault_code` = 1 (protection) and no memory request. An index equal to the size is in range.
- R3: The table entry is read, without lock, at address `cfg_tbl_base + cmd_index*16`. A request holds its address and direction until it is accepted.
- R4: An entry whose bit 0 (valid) is 0, or whose bits 7:1 are not all zero, ends the command with `fault_code` = 1 after that single read, with no descriptor access.
- R5: The descriptor is read at the address in entry bits 127:64. If descriptor bits 15:2 or bits 31:24 are nonzero, the command faults with code 1, nothing is written and the lock drops.
- R6: Otherwise the descriptor is written back to the same address with pending bit (64 + u) set, where u is entry bits 13:8 (entry bits 15:14 are ignored). All other pending bits are preserved.
- R7: A notification is raised only when descriptor bit 1 (suppress) and bit 0 (outstanding) are both 0, and in that case bit 0 is written back as 1. Otherwise no notification is raised, and bits 1:0 are written back unchanged.
- R8: The notification's vector is descriptor bits 23:16. Its destination is descriptor bits 63:32 when `cfg_ext_mode` is 1, and otherwise the zero-extended bits 47:40. The request holds its value until `ntf_ready`.
- R9: `mem_lock` is high from the descriptor read request until the write-back is accepted or the reserved-bit fault is reported. It is low for the entry read and while the notification waits.
- R10: `busy` is high from the cycle after acceptance until the completion pulse. `done` and `fault` never coincide. A command presented while busy is ignored.
- R11: After reset, `busy`, `done`, `fault`, `mem_req_valid`, `mem_lock` and `ntf_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken while not busy |
| cmd_index | input | IDX_W | Target table index |
| busy | output | 1 | Command in progress |
| cfg_enable | input | 1 | Feature enable |
| cfg_tbl_base | input | ADDR_W | Target table base address |
| cfg_tbl_size | input | IDX_W | Highest legal index |
| cfg_ext_mode | input | 1 | 32-bit destination mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Line address |
| mem_req_wdata | output | 128 | Write line |
| mem_lock | output | 1 | Locked access in progress |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Read line |
| ntf_valid | output | 1 | Notification request |
| ntf_ready | input | 1 | Notification accepted |
| ntf_vector | output | 8 | Notification vector |
| ntf_dest | output | 32 | Notification destination ID |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Faulting completion pulse |
| fault_code | output | 2 | 1 protection, 2 invalid operation, 0 otherwise |

## Verification
The assertions assume that memory returns exactly one response beat for each accepted read, and only while the engine waits for one. They also assume that the configuration inputs stay steady while a command runs. The bench's memory model answers each accepted read one cycle later and never sends an unsolicited beat. The bench changes the base, size, mode and enable inputs only between commands. Request and notification back-pressure is applied freely, because the hold properties are written to tolerate any ready pattern.

// File: rtl/uipi_post_engine.sv
module uipi_post_engine #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [IDX_W-1:0]  cmd_index,
  output logic              busy,
  input  logic              cfg_enable,
  input  logic [ADDR_W-1:0] cfg_tbl_base,
  input  logic [IDX_W-1:0]  cfg_tbl_size,
  input  logic              cfg_ext_mode,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [127:0]      mem_req_wdata,
  output logic              mem_lock,
  input  logic              mem_rsp_valid,
  input  logic [127:0]      mem_rsp_data,
  output logic              ntf_valid,
  input  logic              ntf_ready,
  output logic [7:0]        ntf_vector,
  output logic [31:0]       ntf_dest,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_code
);
  localparam int PND_W = 64;
  localparam int UV_W  = $clog2(PND_W);
  localparam logic [1:0] FLT_GP = 2'd1;
  localparam logic [1:0] FLT_UD = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_ENT_REQ, S_ENT_WAIT, S_DSC_REQ, S_DSC_WAIT, S_WB_REQ, S_NTF
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [UV_W-1:0]   uv_q;
  logic [127:0]      line_q;
  logic              ntf_q;
  logic [7:0]        vec_q;
  logic [31:0]       dest_q;
  logic              done_q, fault_q;
  logic [1:0]        code_q;

  wire ent_bad  = ~mem_rsp_data[0] | (|mem_rsp_data[7:1]);
  wire dsc_bad  = (|mem_rsp_data[15:2]) | (|mem_rsp_data[31:24]);
  wire dsc_ntf  = ~mem_rsp_data[1] & ~mem_rsp_data[0];
  wire [PND_W-1:0] pnd_set = mem_rsp_data[127:64] | (PND_W'(1) << uv_q);
  wire [127:0] dsc_upd = {pnd_set, mem_rsp_data[63:1], mem_rsp_data[0] | dsc_ntf};
  wire [31:0] dsc_dest = cfg_ext_mode ? mem_rsp_data[63:32] : {24'd0, mem_rsp_data[47:40]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      uv_q    <= '0;
      line_q  <= '0;
      ntf_q   <= 1'b0;
      vec_q   <= '0;
      dest_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      code_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (!cfg_enable) begin
            fault_q <= 1'b1;
            code_q  <= FLT_UD;
          end else if (cmd_index > cfg_tbl_size) begin
            fault_q <= 1'b1;
            code_q  <= FLT_GP;
          end else begin
            addr_q <= cfg_tbl_base + (ADDR_W'(cmd_index) << 4);
            st     <= S_ENT_REQ;
          end
        end
        S_ENT_REQ: if (mem_req_ready) st <= S_ENT_WAIT;
        S_ENT_WAIT: if (mem_rsp_valid) begin
          if (ent_bad) begin
            fault_q <= 1'b1;
            code_q  <= FLT_GP;
            st      <= S_IDLE;
          end else begin
            uv_q   <= mem_rsp_data[8 +: UV_W];
            addr_q <= mem_rsp_data[64 +: ADDR_W];
            st     <= S_DSC_REQ;
          end
        end
        S_DSC_REQ: if (mem_req_ready) st <= S_DSC_WAIT;
        S_DSC_WAIT: if (mem_rsp_valid) begin
          if (dsc_bad) begin
            fault_q <= 1'b1;
            code_q  <= FLT_GP;
            st      <= S_IDLE;
          end else begin
            line_q <= dsc_upd;
            ntf_q  <= dsc_ntf;
            vec_q  <= mem_rsp_data[23:16];
            dest_q <= dsc_dest;
            st     <= S_WB_REQ;
          end
        end
        S_WB_REQ: if (mem_req_ready) begin
          if (ntf_q) st <= S_NTF;
          else begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_NTF: if (ntf_ready) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_ENT_REQ) || (st == S_DSC_REQ) || (st == S_WB_REQ);
  assign mem_req_write = (st == S_WB_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = line_q;
  assign mem_lock      = (st == S_DSC_REQ) || (st == S_DSC_WAIT) || (st == S_WB_REQ);
  assign ntf_valid     = (st == S_NTF);
  assign ntf_vector    = vec_q;
  assign ntf_dest      = dest_q;
  assign done          = done_q;
  assign fault         = fault_q;
  assign fault_code    = fault_q ? code_q : 2'd0;

  assert_ud_nomem_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_valid && !cfg_enable) |=> (fault && fault_code == FLT_UD && !mem_req_valid && !busy));

  assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_valid && cfg_enable && cmd_index > cfg_tbl_size) |=> (fault && fault_code == FLT_GP && !mem_req_valid));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  assert_wr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_lock);

  assert_ntf_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> !mem_lock);

  assert_ntf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_vector) && $stable(ntf_dest)));

  assert_end_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> (!busy && !(done && fault)));

  assert_wb_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[64 + uv_q]);
endmodule

// File: tb/uipi_post_engine_tb.sv
`timescale 1ns/1ps
module uipi_post_engine_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [15:0]  cmd_index = '0;
  logic         busy;
  logic         cfg_enable = 1'b1;
  logic [63:0]  cfg_tbl_base = 64'h100;
  logic [15:0]  cfg_tbl_size = 16'd15;
  logic         cfg_ext_mode = 1'b0;
  logic         mem_req_valid, mem_req_write, mem_lock;
  logic         mem_req_ready;
  logic [63:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic         ntf_valid, ntf_ready;
  logic [7:0]   ntf_vector;
  logic [31:0]  ntf_dest;
  logic         done, fault;
  logic [1:0]   fault_code;

  uipi_post_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_index(cmd_index), .busy(busy),
    .cfg_enable(cfg_enable), .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_size(cfg_tbl_size),
    .cfg_ext_mode(cfg_ext_mode), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_lock(mem_lock), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .ntf_vector(ntf_vector), .ntf_dest(ntf_dest),
    .done(done), .fault(fault), .fault_code(fault_code)
  );

  logic [127:0] mem [256];
  logic         ld_en = 1'b0;
  logic [7:0]   ld_line = '0;
  logic [127:0] ld_data = '0;
  logic         stall_en = 1'b0;
  logic         tog = 1'b1;
  logic         ntf_hold = 1'b0;
  int rd_cnt = 0, wr_cnt = 0, lrd_cnt = 0, ntf_cnt = 0, flt_cnt = 0;
  logic [63:0]  ent_addr_seen = '0;
  logic [7:0]   ntf_vec_seen = '0;
  logic [31:0]  ntf_dest_seen = '0;

  assign mem_req_ready = tog;
  assign ntf_ready = ~ntf_hold;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (ld_en) mem[ld_line] = ld_data;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[11:4]] = mem_req_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rsp_data  <= mem[mem_req_addr[11:4]];
        mem_rsp_valid <= 1'b1;
        rd_cnt = rd_cnt + 1;
        if (mem_lock) lrd_cnt = lrd_cnt + 1;
        else ent_addr_seen = mem_req_addr;
      end
    end
    if (ntf_valid && ntf_ready) begin
      ntf_cnt = ntf_cnt + 1;
      ntf_vec_seen = ntf_vector;
      ntf_dest_seen = ntf_dest;
    end
    if (fault) flt_cnt = flt_cnt + 1;
    tog <= stall_en ? ~tog : 1'b1;
  end

  typedef struct packed {
    logic [15:0] idx;
    logic [63:0] ent;
    logic [63:0] dsc;
    logic [63:0] pnd;
    logic        ext;
    logic [1:0]  code;
    logic [1:0]  rd;
    logic        wr;
    logic        ntf;
    logic [31:0] dest;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{16'd1,  64'h0501, 64'h00003A00_00410000, 64'h0, 1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 32'h3A},
    '{16'd2,  64'h3F01, 64'h12345678_00220000, 64'h1, 1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 32'h12345678},
    '{16'd3,  64'h0A01, 64'h00005500_00300001, 64'h0, 1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 32'h0},
    '{16'd4,  64'h0C01, 64'h00005500_00300002, 64'h0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 32'h0},
    '{16'd5,  64'h0700, 64'h00001100_00200000, 64'h0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0},
    '{16'd6,  64'h0709, 64'h00001100_00200000, 64'h0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0},
    '{16'd7,  64'h0701, 64'h00001100_00200200, 64'h0, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 32'h0},
    '{16'd8,  64'h0701, 64'h00001100_10200000, 64'h0, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 32'h0},
    '{16'd15, 64'h2001, 64'hABCDEF00_00990000, 64'h0, 1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 32'hEF},
    '{16'd16, 64'h0101, 64'h00001100_00200000, 64'h0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 32'h0},
    '{16'd9,  64'h4501, 64'h00000100_00770000, 64'hF0F00000_00000020, 1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 32'h01},
    '{16'd0,  64'h0001, 64'hFFFFFFFF_00FF0003, 64'h0, 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 32'h0}
  };

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] line, input logic [127:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_line = line; ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input logic [15:0] idx, output logic [1:0] code, output logic fin);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 200 && !(done || fault); k++) @(negedge clk);
    code = fault ? fault_code : 2'd0;
    fin = done;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog actual=hang expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] code;
    logic fin;
    int rd0, wr0, lrd0, n0, f0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fault, "R11 reset busy/done/fault", {busy, done, fault}, 0);
    chk(!mem_req_valid && !mem_lock && !ntf_valid, "R11 reset req/lock/ntf",
        {mem_req_valid, mem_lock, ntf_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req_valid, "R11 idle after reset", {busy, mem_req_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [7:0] dl;
      logic [127:0] expd;
      v = VEC[i];
      dl = 8'h80 + v.idx[7:0];
      load(8'h10 + v.idx[7:0], {64'h800 + {44'd0, v.idx, 4'd0}, v.ent});
      load(dl, {v.pnd, v.dsc});
      cfg_ext_mode = v.ext;
      rd0 = rd_cnt; wr0 = wr_cnt; lrd0 = lrd_cnt; n0 = ntf_cnt;
      run(v.idx, code, fin);
      chk(code == v.code && fin == (v.code == 2'd0), $sformatf("R2 R4 R5 outcome vec %0d", i),
          {code, fin}, {v.code, v.code == 2'd0});
      chk(rd_cnt - rd0 == int'(v.rd) && wr_cnt - wr0 == int'(v.wr), $sformatf("R2 R4 R5 access count vec %0d", i),
          (rd_cnt - rd0) * 16 + (wr_cnt - wr0), int'(v.rd) * 16 + int'(v.wr));
      chk(lrd_cnt - lrd0 == (v.rd == 2'd2 ? 1 : 0), $sformatf("R9 locked reads vec %0d", i),
          lrd_cnt - lrd0, (v.rd == 2'd2 ? 1 : 0));
      if (v.rd != 2'd0)
        chk(ent_addr_seen == 64'h100 + {44'd0, v.idx, 4'd0}, $sformatf("R3 entry address vec %0d", i),
            ent_addr_seen, 64'h100 + {44'd0, v.idx, 4'd0});
      if (v.code == 2'd0)
        expd = {v.pnd | (64'd1 << v.ent[13:8]), v.dsc[63:1], v.dsc[0] | v.ntf};
      else
        expd = {v.pnd, v.dsc};
      chk(mem[dl] == expd, $sformatf("R6 R7 descriptor vec %0d", i), mem[dl], expd);
      chk(ntf_cnt - n0 == int'(v.ntf), $sformatf("R7 notify count vec %0d", i), ntf_cnt - n0, v.ntf);
      if (v.ntf)
        chk(ntf_vec_seen == v.dsc[23:16] && ntf_dest_seen == v.dest, $sformatf("R8 notify fields vec %0d", i),
            {ntf_vec_seen, ntf_dest_seen}, {v.dsc[23:16], v.dest});
    end

    cfg_enable = 1'b0;
    rd0 = rd_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 16'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(fault && fault_code == 2'd2 && !busy, "R1 invalid-op fault next cycle", {fault, fault_code, busy}, 4'b1100);
    chk(rd_cnt == rd0, "R1 no memory access", rd_cnt - rd0, 0);
    cfg_enable = 1'b1;

    load(8'h11, {64'h810, 64'h0501});
    load(8'h81, {64'h0, 64'h00003A00_00410000});
    cfg_ext_mode = 1'b0;
    stall_en = 1'b1; ntf_hold = 1'b1;
    f0 = flt_cnt; wr0 = wr_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 16'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy, "R10 busy after accept", busy, 1);
    cmd_valid = 1'b1; cmd_index = 16'd16;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 100 && !ntf_valid; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ntf_valid && ntf_dest == 32'h3A && ntf_vector == 8'h41, "R8 notify held under back-pressure",
        {ntf_valid, ntf_vector, ntf_dest}, {1'b1, 8'h41, 32'h3A});
    chk(!mem_lock && busy, "R9 lock released while notifying", {mem_lock, busy}, 2'b01);
    ntf_hold = 1'b0;
    for (int k = 0; k < 100 && !(done || fault); k++) @(negedge clk);
    chk(done && !fault, "R10 done pulse", {done, fault}, 2'b10);
    @(negedge clk);
    chk(!done && !busy, "R10 single-cycle done", {done, busy}, 0);
    chk(flt_cnt == f0, "R10 command while busy ignored", flt_cnt - f0, 0);
    chk(wr_cnt - wr0 == 1 && mem[8'h81] == {64'h20, 64'h00003A00_00410001}, "R6 write-back under stall",
        mem[8'h81], {64'h20, 64'h00003A00_00410001});
    stall_en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule